// File: doc/BRIEF.md
# Almost-Flag Threshold Register Block

This block holds the two thresholds that a FIFO uses to raise its almost-empty and almost-full warnings, and turns the FIFO's current word count into those two registered flags. A master reset loads a default pair of thresholds chosen from eight preset values. The same reset also latches whether later updates arrive one bit at a time on a serial input or as whole words on the write data bus.

After reset, a shared load-select input switches the write and read data ports from normal traffic to threshold access. Parallel writes and readbacks step through the two registers in turn, almost-empty first. Serial updates fill the almost-empty register and then the almost-full register, least significant bit first. A partial reset returns the access sequencing to its start and keeps the thresholds and the update method. All inputs are sampled on one clock. The serial, write and read strobes are enables qualified on that clock.

Top module: `pfo_loader`

## Requirements
- R1: While `mrst_i` is high, the 3-bit code k = {`ld_i`, `fsel_i[1]`, `fsel_i[0]`} is applied, and both thresholds load the value 2^(k+3)-1 (7, 15, 31 up to 1023). `rd_data_o`, `almost_empty_o` and `almost_full_o` read 0 during master reset.
- R2: The level of `ld_i` during master reset fixes the update method until the next master reset. High selects serial and low selects parallel.
- R3: In serial mode, each cycle with `ser_en_i` high writes `ser_di_i` into the next bit position. Positions 0..OFS_W-1 are the almost-empty threshold and OFS_W..2*OFS_W-1 are the almost-full threshold, both LSB first. After the last position the position returns to 0.
- R4: In parallel mode, a cycle with `ld_i` and `wr_en_i` high stores `wr_data_i` into the register that an access pointer selects. The pointer alternates almost-empty, almost-full, and so on, and starts at almost-empty after either reset. Only the selected register changes.
- R5: A cycle with `ld_i` and `rd_en_i` high places the selected register on `rd_data_o` one cycle later and advances the same pointer. If a parallel write is accepted in that cycle, the write proceeds, the read is dropped and `rd_data_o` holds.
- R6: `prst_i` keeps both thresholds and the update method. It returns the pointer to almost-empty and the serial position to 0, and clears `rd_data_o` and both flags.
- R7: One cycle after `word_cnt_i` is applied, `almost_empty_o` is high exactly when `word_cnt_i` is at or below the almost-empty threshold.
- R8: One cycle after `word_cnt_i` is applied, `almost_full_o` is high exactly when DEPTH minus `word_cnt_i` is at or below the almost-full threshold.
- R9: Serial strobes have no effect in parallel mode. Parallel writes have no effect in serial mode and do not advance the pointer.
- R10: With `ld_i` low, `wr_en_i` and `rd_en_i` leave the thresholds, the pointer and `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| mrst_i | input | 1 | Master reset, synchronous, active high |
| prst_i | input | 1 | Partial reset, synchronous, active high |
| fsel_i | input | 2 | Default threshold select, low two bits of the code |
| ld_i | input | 1 | Code MSB and method select at master reset; threshold access select afterwards |
| ser_en_i | input | 1 | Serial bit strobe |
| ser_di_i | input | 1 | Serial data bit |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | OFS_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | OFS_W | Threshold readback |
| word_cnt_i | input | CNT_W | Words currently stored in the FIFO |
| almost_empty_o | output | 1 | Almost-empty flag |
| almost_full_o | output | 1 | Almost-full flag |

## Verification
A threshold write or serial bit lands at the first rising edge after the stimulus. A readback appears on `rd_data_o` at the edge that samples the read strobe. Each flag follows `word_cnt_i` after one register stage, and follows a threshold change after two. The bench drives every input on the falling edge and reads each result on the next falling edge, after exactly one rising edge. Flag checks use thresholds that were settled several cycles earlier.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        ofs_sel_e sel;
    } par_cmd_t;

    localparam int DFLT_SHIFT = 3;

    // preset threshold for a 3-bit code: 2^(code+3)-1
    function automatic int unsigned default_offset(input logic [2:0] code);
        return (32'd1 << (int'(code) + DFLT_SHIFT)) - 32'd1;
    endfunction

endpackage

// File: rtl/pfo_ctrl.sv
module pfo_ctrl
    import pfo_pkg::*;
#(
    parameter int  OFS_W = 10,
    localparam int BITS  = 2 * OFS_W,
    localparam int POS_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             ld,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             ser_en,
    output par_cmd_t         cmd,
    output logic             ser_we,
    output logic [POS_W-1:0] ser_pos
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BITS - 1);

    load_mode_e       mode_q;
    ofs_sel_e         sel_q;
    logic [POS_W-1:0] pos_q;
    logic             in_rst;
    logic             wr_go;
    logic             rd_go;
    logic             sh_go;

    assign in_rst = mrst | prst;
    assign wr_go  = !in_rst && ld && wr_en && (mode_q == LOAD_PAR);
    assign rd_go  = !in_rst && ld && rd_en && !wr_go;
    assign sh_go  = !in_rst && ser_en && (mode_q == LOAD_SER);

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode_q <= ld ? LOAD_SER : LOAD_PAR;
        end
    end

    always_ff @(posedge clk) begin
        if (in_rst) begin
            sel_q <= SEL_AE;
        end else if (wr_go || rd_go) begin
            sel_q <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end

    always_ff @(posedge clk) begin
        if (in_rst) begin
            pos_q <= '0;
        end else if (sh_go) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    assign cmd.wr  = wr_go;
    assign cmd.rd  = rd_go;
    assign cmd.sel = sel_q;
    assign ser_we  = sh_go;
    assign ser_pos = pos_q;

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        !mrst |=> $stable(mode_q));

    // R3
    ser_wrap_chk: assert property (@(posedge clk) disable iff (in_rst)
        (sh_go && pos_q == LAST_POS) |=> (pos_q == '0));

    // R10
    idle_sel_chk: assert property (@(posedge clk) disable iff (in_rst)
        !ld |=> $stable(sel_q));

endmodule

// File: rtl/pfo_offsets.sv
module pfo_offsets
    import pfo_pkg::*;
#(
    parameter int  OFS_W = 10,
    localparam int POS_W = $clog2(2 * OFS_W)
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic [2:0]       dflt_code,
    input  par_cmd_t         cmd,
    input  logic [OFS_W-1:0] wr_data,
    input  logic             ser_we,
    input  logic [POS_W-1:0] ser_pos,
    input  logic             ser_di,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] rd_data
);

    logic [OFS_W-1:0] ae_q;
    logic [OFS_W-1:0] af_q;
    logic [OFS_W-1:0] rd_q;
    logic [OFS_W-1:0] ae_mask;
    logic [OFS_W-1:0] af_mask;
    logic [OFS_W-1:0] dflt_val;

    // one-hot bit-enable masks for the serial write position
    for (genvar b = 0; b < OFS_W; b++) begin : g_mask
        assign ae_mask[b] = ser_we && (ser_pos == POS_W'(b));
        assign af_mask[b] = ser_we && (ser_pos == POS_W'(b + OFS_W));
    end

    assign dflt_val = OFS_W'(default_offset(dflt_code));

    always_ff @(posedge clk) begin
        if (mrst) begin
            ae_q <= dflt_val;
            af_q <= dflt_val;
        end else if (!prst) begin
            if (cmd.wr && cmd.sel == SEL_AE) begin
                ae_q <= wr_data;
            end else begin
                ae_q <= (ae_q & ~ae_mask) | ({OFS_W{ser_di}} & ae_mask);
            end
            if (cmd.wr && cmd.sel == SEL_AF) begin
                af_q <= wr_data;
            end else begin
                af_q <= (af_q & ~af_mask) | ({OFS_W{ser_di}} & af_mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            rd_q <= '0;
        end else if (cmd.rd) begin
            rd_q <= (cmd.sel == SEL_AE) ? ae_q : af_q;
        end
    end

    assign ae_ofs  = ae_q;
    assign af_ofs  = af_q;
    assign rd_data = rd_q;

    // R6
    keep_on_prst_chk: assert property (@(posedge clk) disable iff (mrst)
        prst |=> ($stable(ae_q) && $stable(af_q)));

    // R4
    af_untouched_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (cmd.wr && cmd.sel == SEL_AE && !ser_we) |=> $stable(af_q));

    // R10
    quiet_regs_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (!cmd.wr && !ser_we) |=> ($stable(ae_q) && $stable(af_q)));

endmodule

// File: rtl/pfo_flags.sv
module pfo_flags #(
    parameter int  OFS_W = 10,
    parameter int  DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic [CNT_W-1:0] word_cnt,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             almost_empty,
    output logic             almost_full
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_w;
    logic             ae_q;
    logic             af_q;

    assign free_w = FULL_CNT - word_cnt;

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            ae_q <= 1'b0;
            af_q <= 1'b0;
        end else begin
            ae_q <= (word_cnt <= CNT_W'(ae_ofs));
            af_q <= (free_w <= CNT_W'(af_ofs));
        end
    end

    assign almost_empty = ae_q;
    assign almost_full  = af_q;

    // R7
    empty_floor_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (word_cnt == '0) |=> ae_q);

    // R8
    full_ceiling_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (word_cnt == FULL_CNT) |=> af_q);

endmodule

// File: rtl/pfo_loader.sv
module pfo_loader
    import pfo_pkg::*;
#(
    parameter int  OFS_W = 10,
    parameter int  DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             mrst_i,
    input  logic             prst_i,
    input  logic [1:0]       fsel_i,
    input  logic             ld_i,
    input  logic             ser_en_i,
    input  logic             ser_di_i,
    input  logic             wr_en_i,
    input  logic [OFS_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [OFS_W-1:0] rd_data_o,
    input  logic [CNT_W-1:0] word_cnt_i,
    output logic             almost_empty_o,
    output logic             almost_full_o
);

    localparam int POS_W = $clog2(2 * OFS_W);

    par_cmd_t         cmd;
    logic             ser_we;
    logic [POS_W-1:0] ser_pos;
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;

    pfo_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk     (clk),
        .mrst    (mrst_i),
        .prst    (prst_i),
        .ld      (ld_i),
        .wr_en   (wr_en_i),
        .rd_en   (rd_en_i),
        .ser_en  (ser_en_i),
        .cmd     (cmd),
        .ser_we  (ser_we),
        .ser_pos (ser_pos)
    );

    pfo_offsets #(.OFS_W(OFS_W)) u_offsets (
        .clk       (clk),
        .mrst      (mrst_i),
        .prst      (prst_i),
        .dflt_code ({ld_i, fsel_i}),
        .cmd       (cmd),
        .wr_data   (wr_data_i),
        .ser_we    (ser_we),
        .ser_pos   (ser_pos),
        .ser_di    (ser_di_i),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs),
        .rd_data   (rd_data_o)
    );

    pfo_flags #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_flags (
        .clk          (clk),
        .mrst         (mrst_i),
        .prst         (prst_i),
        .word_cnt     (word_cnt_i),
        .ae_ofs       (ae_ofs),
        .af_ofs       (af_ofs),
        .almost_empty (almost_empty_o),
        .almost_full  (almost_full_o)
    );

endmodule

// File: tb/tb_pfo_loader.sv
`timescale 1ns/1ps
module tb_pfo_loader;

    localparam int OFS_W = 10;
    localparam int DEPTH = 1024;
    localparam int CNT_W = 11;

    // {word count, expected almost-empty, expected almost-full} with both thresholds at 63
    localparam logic [12:0] FLAG_VEC [8] = '{
        {11'd0,    1'b1, 1'b0},
        {11'd62,   1'b1, 1'b0},
        {11'd63,   1'b1, 1'b0},
        {11'd64,   1'b0, 1'b0},
        {11'd500,  1'b0, 1'b0},
        {11'd960,  1'b0, 1'b0},
        {11'd961,  1'b0, 1'b1},
        {11'd1024, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             mrst_i = 1'b1;
    logic             prst_i = 1'b0;
    logic [1:0]       fsel_i = 2'd3;
    logic             ld_i = 1'b0;
    logic             ser_en_i = 1'b0;
    logic             ser_di_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [OFS_W-1:0] wr_data_i = '0;
    logic             rd_en_i = 1'b0;
    logic [OFS_W-1:0] rd_data_o;
    logic [CNT_W-1:0] word_cnt_i = '0;
    logic             almost_empty_o;
    logic             almost_full_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pfo_loader #(.OFS_W(OFS_W), .DEPTH(DEPTH)) dut (
        .clk            (clk),
        .mrst_i         (mrst_i),
        .prst_i         (prst_i),
        .fsel_i         (fsel_i),
        .ld_i           (ld_i),
        .ser_en_i       (ser_en_i),
        .ser_di_i       (ser_di_i),
        .wr_en_i        (wr_en_i),
        .wr_data_i      (wr_data_i),
        .rd_en_i        (rd_en_i),
        .rd_data_o      (rd_data_o),
        .word_cnt_i     (word_cnt_i),
        .almost_empty_o (almost_empty_o),
        .almost_full_o  (almost_full_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic master_reset(input logic ld_lvl, input logic [1:0] fs);
        mrst_i = 1'b1;
        ld_i   = ld_lvl;
        fsel_i = fs;
        step();
        step();
        mrst_i = 1'b0;
        ld_i   = 1'b0;
    endtask

    task automatic rd_one(input string req, input int exp);
        ld_i = 1'b1; rd_en_i = 1'b1;
        step();
        ld_i = 1'b0; rd_en_i = 1'b0;
        chk(req, int'(rd_data_o), exp);
    endtask

    task automatic wr_one(input int val);
        ld_i = 1'b1; wr_en_i = 1'b1; wr_data_i = OFS_W'(val);
        step();
        ld_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic shift_word(input int val);
        for (int i = 0; i < OFS_W; i++) begin
            ser_en_i = 1'b1;
            ser_di_i = val[i];
            step();
        end
        ser_en_i = 1'b0;
        ser_di_i = 1'b0;
    endtask

    task automatic flag_at(input string req, input int cnt, input bit ae, input bit af);
        word_cnt_i = CNT_W'(cnt);
        step();
        chk({req, " almost_empty"}, int'(almost_empty_o), int'(ae));
        chk({req, " almost_full"}, int'(almost_full_o), int'(af));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // reset state during master reset, code 3 -> 63, parallel
        ld_i = 1'b0; fsel_i = 2'd3;
        step();
        step();
        chk("R1 rd_data in reset", int'(rd_data_o), 0);
        chk("R1 almost_empty in reset", int'(almost_empty_o), 0);
        chk("R1 almost_full in reset", int'(almost_full_o), 0);
        mrst_i = 1'b0;
        step();
        rd_one("R1 default AE code3", 63);
        rd_one("R1 default AF code3", 63);

        // R7 R8 table of flag vectors
        for (int v = 0; v < 8; v++) begin
            flag_at("R7/R8 vector", int'(FLAG_VEC[v][12:2]), FLAG_VEC[v][1], FLAG_VEC[v][0]);
        end

        // R4 alternating parallel writes, R5 readback
        wr_one(100);
        wr_one(200);
        rd_one("R4 AE after write", 100);
        rd_one("R5 AF after write", 200);
        flag_at("R7 at AE threshold", 100, 1'b1, 1'b0);
        flag_at("R7 above AE threshold", 101, 1'b0, 1'b0);
        flag_at("R8 free at AF threshold", 824, 1'b0, 1'b1);
        flag_at("R8 free above AF threshold", 823, 1'b0, 1'b0);

        // R6 partial reset with pointer left on AF
        wr_one(5);
        prst_i = 1'b1;
        step();
        chk("R6 rd_data cleared", int'(rd_data_o), 0);
        chk("R6 almost_full cleared", int'(almost_full_o), 0);
        prst_i = 1'b0;
        rd_one("R6 pointer back to AE", 5);
        rd_one("R6 AF kept", 200);

        // R10 strobes without load select
        wr_en_i = 1'b1; rd_en_i = 1'b1; wr_data_i = OFS_W'(777);
        step();
        step();
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R10 rd_data unchanged", int'(rd_data_o), 200);
        rd_one("R10 AE and pointer unchanged", 5);
        rd_one("R10 AF unchanged", 200);

        // R5 write and read in the same cycle
        ld_i = 1'b1; wr_en_i = 1'b1; rd_en_i = 1'b1; wr_data_i = OFS_W'(11);
        step();
        ld_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R5 read dropped on collision", int'(rd_data_o), 200);
        rd_one("R5 pointer advanced once", 200);
        rd_one("R5 collided write landed", 11);

        // R2 serial method, code 4 -> 127
        master_reset(1'b1, 2'd0);
        rd_one("R1 default AE code4", 127);
        rd_one("R1 default AF code4", 127);
        shift_word(37);
        shift_word(600);
        rd_one("R3 serial AE", 37);
        rd_one("R3 serial AF", 600);
        wr_one(1);
        rd_one("R9 parallel write ignored in serial", 37);
        rd_one("R9 AF intact in serial", 600);
        shift_word(3);
        rd_one("R3 position wrapped to AE", 3);
        rd_one("R3 AF after wrap", 600);
        prst_i = 1'b1;
        step();
        prst_i = 1'b0;
        shift_word(9);
        rd_one("R6 serial method kept", 9);
        rd_one("R6 AF kept in serial", 600);

        // R2 parallel method again, code 0 -> 7, serial ignored
        master_reset(1'b0, 2'd0);
        for (int i = 0; i < 5; i++) begin
            ser_en_i = 1'b1; ser_di_i = 1'b1;
            step();
        end
        ser_en_i = 1'b0; ser_di_i = 1'b0;
        rd_one("R9 serial ignored in parallel", 7);
        flag_at("R7 low threshold edge", 7, 1'b1, 1'b0);
        flag_at("R7 low threshold above", 8, 1'b0, 1'b0);
        flag_at("R8 low threshold edge", 1017, 1'b0, 1'b1);
        flag_at("R8 low threshold below", 1016, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule